// File: doc/BRIEF.md
# Masked Set/Clear Interrupt Request Register

This block holds the six interrupt request flags of a contactless reader controller and sits on a simple host register bus. The controller core reports events to it as single-cycle strobes: the countdown timer reaching zero, the end of a transmit phase, the end of a reception, a command returning to idle, and an unknown command code being started. The FIFO high and low alert conditions arrive as levels, and the block turns their rising edges into events. Each event sets its flag, and the flag stays set until the host changes it.

The host changes flags with a single write to the flag address. The top data bit picks the direction, and the six low data bits pick which flags are affected. A direction bit of 1 sets every marked flag. A direction bit of 0 clears every marked flag. Unmarked flags keep their value. If the same cycle brings a hardware event and a host clear for one flag, the event wins. A separate enable register selects which flags drive the active-high `irq` output. When the host itself starts the Idle command, the idle event of that cycle is dropped, so the host does not interrupt itself.

Top module: `irq_flag_reg`

## Requirements
- R1: After reset, the flag register (address 07h) and the enable register (address 06h) both read 00h, and `irq` is 0.
- R2: A host write to 07h with data bit 7 = 1 sets every flag whose bit is 1 in data bits 5..0. All other flags keep their value.
- R3: A host write to 07h with data bit 7 = 0 clears every flag whose bit is 1 in data bits 5..0. All other flags keep their value.
- R4: `ev_timer_zero` sets flag bit 5, `ev_tx_done` sets bit 4, and `ev_rx_end` sets bit 3. The flag is visible on the clock edge that samples the strobe.
- R5: `ev_cmd_finish` or `ev_cmd_unknown` sets the idle flag at bit 2.
- R6: If `ev_host_idle` is high in the same cycle, the idle flag is not set by `ev_cmd_finish` or `ev_cmd_unknown`.
- R7: Flag bit 1 is set only on a rising edge of `lvl_fifo_hi`, and flag bit 0 only on a rising edge of `lvl_fifo_lo`. If the level stays high after the host clears the flag, the flag is not set again.
- R8: If a hardware set and a host clear hit the same flag in the same cycle, the flag ends up set.
- R9: Reads of 07h return {2'b00, flags}. Bit 7 (the write-only direction bit) and bit 6 (reserved) read 0. A write to 06h stores data bits 5..0 as the enable mask, and reads of 06h return {2'b00, mask}.
- R10: `irq` is 1 exactly when some flag is set and its enable bit is also 1.
- R11: Writes to any address other than 06h and 07h change neither the flags nor the enable mask. Reads of other addresses return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Host write strobe |
| bus_addr | input | 8 | Host register address |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data, a combinational function of `bus_addr` |
| ev_timer_zero | input | 1 | Strobe: the timer reached zero |
| ev_tx_done | input | 1 | Strobe: transmit, programming or checksum phase finished |
| ev_rx_end | input | 1 | Strobe: the receiver terminated |
| ev_cmd_finish | input | 1 | Strobe: a running command ended and returned to idle |
| ev_cmd_unknown | input | 1 | Strobe: an unknown command code was started |
| ev_host_idle | input | 1 | Strobe: the host wrote the Idle command |
| lvl_fifo_hi | input | 1 | FIFO high alert level |
| lvl_fifo_lo | input | 1 | FIFO low alert level |
| irq | output | 1 | Combined active-high interrupt request |

## Verification
The assertions assume three things about the inputs:
- Every event strobe is synchronous to `clk` and lasts one cycle.
- The alert levels are clean synchronous signals.
- `ev_host_idle` comes only from a host Idle write, so any idle event in that same cycle counts as host-caused.

The bench drives all inputs on the falling clock edge. It builds each strobe as an independent single-cycle draw from `$urandom`, and it toggles the alert levels at random. This lets repeated high cycles exercise the no-retrigger rule. Directed sequences cover the collisions: a host clear meeting an event on the same flag, and a host Idle start meeting an idle event.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;

    localparam int NUM_FLAGS = 6;
    localparam int DATA_W    = 8;

    // Flag bit positions inside the register (decoded by software)
    localparam int BIT_TIMER = 5;
    localparam int BIT_TX    = 4;
    localparam int BIT_RX    = 3;
    localparam int BIT_IDLE  = 2;
    localparam int BIT_HI    = 1;
    localparam int BIT_LO    = 0;

    // Position of the set/clear direction bit in write data
    localparam int BIT_DIR   = DATA_W - 1;

    // Number of level alerts that go through edge detection
    localparam int NUM_ALERTS = 2;

    typedef logic [NUM_FLAGS-1:0] flag_vec_t;

    typedef struct packed {
        flag_vec_t flags;
        flag_vec_t enables;
    } core_state_t;

endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_in,
    output logic [WIDTH-1:0] rise_out
);

    typedef struct packed {
        logic [WIDTH-1:0] prev;
    } edge_state_t;

    edge_state_t state_d, state_q;

    always_comb begin
        state_d      = state_q;
        state_d.prev = level_in;
    end

    // One rise detector per alert line
    for (genvar i = 0; i < WIDTH; i++) begin : g_rise
        assign rise_out[i] = level_in[i] & ~state_q.prev[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/irq_event_map.sv
module irq_event_map
    import irq_flag_pkg::*;
(
    input  logic                  ev_timer_zero,
    input  logic                  ev_tx_done,
    input  logic                  ev_rx_end,
    input  logic                  ev_cmd_finish,
    input  logic                  ev_cmd_unknown,
    input  logic                  ev_host_idle,
    input  logic [NUM_ALERTS-1:0] alert_rise,
    output flag_vec_t             hw_set
);

    logic idle_event;

    always_comb begin
        // An idle event caused by the host's own Idle write is dropped
        idle_event = (ev_cmd_finish | ev_cmd_unknown) & ~ev_host_idle;

        hw_set            = '0;
        hw_set[BIT_TIMER] = ev_timer_zero;
        hw_set[BIT_TX]    = ev_tx_done;
        hw_set[BIT_RX]    = ev_rx_end;
        hw_set[BIT_IDLE]  = idle_event;
        hw_set[BIT_HI]    = alert_rise[1];
        hw_set[BIT_LO]    = alert_rise[0];
    end

endmodule

// File: rtl/irq_host_port.sv
module irq_host_port
    import irq_flag_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'h07,
    parameter logic [ADDR_W-1:0] EN_ADDR   = 8'h06
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  flag_vec_t         flags_q,
    input  flag_vec_t         enables_q,
    output flag_vec_t         host_set,
    output flag_vec_t         host_clr,
    output logic              en_we,
    output flag_vec_t         en_wdata,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam int PAD_W = DATA_W - NUM_FLAGS;

    logic      hit_flag;
    logic      hit_en;
    flag_vec_t mask;

    always_comb begin
        hit_flag = (bus_addr == FLAG_ADDR);
        hit_en   = (bus_addr == EN_ADDR);
        mask     = bus_wdata[NUM_FLAGS-1:0];

        host_set = '0;
        host_clr = '0;
        if (bus_wr && hit_flag) begin
            if (bus_wdata[BIT_DIR]) begin
                host_set = mask;
            end else begin
                host_clr = mask;
            end
        end

        en_we    = bus_wr && hit_en;
        en_wdata = mask;

        // The direction bit and the reserved bit always read zero
        if (hit_flag) begin
            bus_rdata = {{PAD_W{1'b0}}, flags_q};
        end else if (hit_en) begin
            bus_rdata = {{PAD_W{1'b0}}, enables_q};
        end else begin
            bus_rdata = '0;
        end
    end

endmodule

// File: rtl/irq_flag_core.sv
module irq_flag_core
    import irq_flag_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  flag_vec_t hw_set,
    input  flag_vec_t host_set,
    input  flag_vec_t host_clr,
    input  logic      en_we,
    input  flag_vec_t en_wdata,
    output flag_vec_t flags_q,
    output flag_vec_t enables_q,
    output logic      irq
);

    core_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        // A clear is applied first, so any set in the same cycle wins
        state_d.flags = (state_q.flags & ~host_clr) | host_set | hw_set;
        if (en_we) begin
            state_d.enables = en_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign flags_q   = state_q.flags;
    assign enables_q = state_q.enables;
    assign irq       = |(state_q.flags & state_q.enables);

endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg
    import irq_flag_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'h07,
    parameter logic [ADDR_W-1:0] EN_ADDR   = 8'h06
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              ev_timer_zero,
    input  logic              ev_tx_done,
    input  logic              ev_rx_end,
    input  logic              ev_cmd_finish,
    input  logic              ev_cmd_unknown,
    input  logic              ev_host_idle,
    input  logic              lvl_fifo_hi,
    input  logic              lvl_fifo_lo,
    output logic              irq
);

    logic [NUM_ALERTS-1:0] alert_rise;
    flag_vec_t             hw_set;
    flag_vec_t             host_set;
    flag_vec_t             host_clr;
    logic                  en_we;
    flag_vec_t             en_wdata;
    flag_vec_t             flags_q;
    flag_vec_t             enables_q;

    irq_edge_detect #(
        .WIDTH (NUM_ALERTS)
    ) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in ({lvl_fifo_hi, lvl_fifo_lo}),
        .rise_out (alert_rise)
    );

    irq_event_map u_map (
        .ev_timer_zero  (ev_timer_zero),
        .ev_tx_done     (ev_tx_done),
        .ev_rx_end      (ev_rx_end),
        .ev_cmd_finish  (ev_cmd_finish),
        .ev_cmd_unknown (ev_cmd_unknown),
        .ev_host_idle   (ev_host_idle),
        .alert_rise     (alert_rise),
        .hw_set         (hw_set)
    );

    irq_host_port #(
        .ADDR_W    (ADDR_W),
        .FLAG_ADDR (FLAG_ADDR),
        .EN_ADDR   (EN_ADDR)
    ) u_port (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .flags_q   (flags_q),
        .enables_q (enables_q),
        .host_set  (host_set),
        .host_clr  (host_clr),
        .en_we     (en_we),
        .en_wdata  (en_wdata),
        .bus_rdata (bus_rdata)
    );

    irq_flag_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_set    (hw_set),
        .host_set  (host_set),
        .host_clr  (host_clr),
        .en_we     (en_we),
        .en_wdata  (en_wdata),
        .flags_q   (flags_q),
        .enables_q (enables_q),
        .irq       (irq)
    );

endmodule

// File: rtl/irq_flag_reg_chk.sv
module irq_flag_reg_chk
    import irq_flag_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'h07,
    parameter logic [ADDR_W-1:0] EN_ADDR   = 8'h06
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              ev_timer_zero,
    input logic              ev_cmd_finish,
    input logic              ev_cmd_unknown,
    input logic              ev_host_idle,
    input logic              lvl_fifo_hi,
    input logic              irq,
    input flag_vec_t         flags_q,
    input flag_vec_t         enables_q,
    input flag_vec_t         hw_set
);

    logic wr_flag;
    logic wr_en;
    assign wr_flag = bus_wr && (bus_addr == FLAG_ADDR);
    assign wr_en   = bus_wr && (bus_addr == EN_ADDR);

    // R2: a host set write leaves the marked flags set
    a_r2_host_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_flag && bus_wdata[7]) |=> ((flags_q & $past(bus_wdata[5:0])) == $past(bus_wdata[5:0])));

    // R4: the timer strobe sets bit 5 on the next edge
    a_r4_timer_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ev_timer_zero |=> flags_q[BIT_TIMER]);

    // R6: a host-started Idle never raises the idle flag
    a_r6_host_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_host_idle && !flags_q[BIT_IDLE] && !(wr_flag && bus_wdata[7] && bus_wdata[BIT_IDLE]))
        |=> !flags_q[BIT_IDLE]);

    // R5: an unmasked idle event sets bit 2
    a_r5_idle_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_cmd_finish || ev_cmd_unknown) && !ev_host_idle) |=> flags_q[BIT_IDLE]);

    // R8: a hardware set beats a host clear of the same flag
    a_r8_hw_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_flag && !bus_wdata[7] && |(hw_set & bus_wdata[5:0]))
        |=> |(flags_q & $past(hw_set & bus_wdata[5:0])));

    // R9: the direction bit and the reserved bit never read as one
    a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[7:6] == 2'b00);

    // R10: irq follows the enabled flags
    a_r10_irq_map: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (|(flags_q & enables_q)));

    // R11: the enable mask moves only on a write to its address
    a_r11_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(enables_q));

    // R7: a level that is already high does not set the high alert flag
    a_r7_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_fifo_hi && $past(lvl_fifo_hi) && $past(rst_n) && !flags_q[BIT_HI]
         && !(wr_flag && bus_wdata[7] && bus_wdata[BIT_HI]))
        |=> !flags_q[BIT_HI]);

endmodule

bind irq_flag_reg irq_flag_reg_chk #(
    .ADDR_W    (ADDR_W),
    .FLAG_ADDR (FLAG_ADDR),
    .EN_ADDR   (EN_ADDR)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_wr         (bus_wr),
    .bus_addr       (bus_addr),
    .bus_wdata      (bus_wdata),
    .bus_rdata      (bus_rdata),
    .ev_timer_zero  (ev_timer_zero),
    .ev_cmd_finish  (ev_cmd_finish),
    .ev_cmd_unknown (ev_cmd_unknown),
    .ev_host_idle   (ev_host_idle),
    .lvl_fifo_hi    (lvl_fifo_hi),
    .irq            (irq),
    .flags_q        (flags_q),
    .enables_q      (enables_q),
    .hw_set         (hw_set)
);

// File: tb/irq_flag_reg_test.sv
module irq_flag_reg_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       bus_wr;
    logic [7:0] bus_addr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       ev_timer_zero, ev_tx_done, ev_rx_end;
    logic       ev_cmd_finish, ev_cmd_unknown, ev_host_idle;
    logic       lvl_fifo_hi, lvl_fifo_lo;
    logic       irq;

    int checks = 0;
    int fails  = 0;

    // Bench model of the architectural state
    logic [5:0] m_flags, m_en;
    logic       m_prev_hi, m_prev_lo;

    always #4 clk = ~clk; // 125 MHz

    irq_flag_reg uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_wr         (bus_wr),
        .bus_addr       (bus_addr),
        .bus_wdata      (bus_wdata),
        .bus_rdata      (bus_rdata),
        .ev_timer_zero  (ev_timer_zero),
        .ev_tx_done     (ev_tx_done),
        .ev_rx_end      (ev_rx_end),
        .ev_cmd_finish  (ev_cmd_finish),
        .ev_cmd_unknown (ev_cmd_unknown),
        .ev_host_idle   (ev_host_idle),
        .lvl_fifo_hi    (lvl_fifo_hi),
        .lvl_fifo_lo    (lvl_fifo_lo),
        .irq            (irq)
    );

    function automatic logic [5:0] exp_flags(
        input logic [5:0] f, input logic wr, input logic [7:0] a, input logic [7:0] d,
        input logic t, input logic tx, input logic rx, input logic fin, input logic unk,
        input logic hidle, input logic hi, input logic lo, input logic phi, input logic plo);
        logic [5:0] set_m, clr_m, hw;
        set_m = '0;
        clr_m = '0;
        if (wr && a == 8'h07) begin
            if (d[7]) set_m = d[5:0];
            else      clr_m = d[5:0];
        end
        hw = {t, tx, rx, (fin | unk) & ~hidle, hi & ~phi, lo & ~plo};
        return (f & ~clr_m) | set_m | hw;
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        if (a == 8'h07)      return {2'b00, m_flags};
        else if (a == 8'h06) return {2'b00, m_en};
        else                 return 8'h00;
    endfunction

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        bus_wr = 0; bus_wdata = 0;
        ev_timer_zero = 0; ev_tx_done = 0; ev_rx_end = 0;
        ev_cmd_finish = 0; ev_cmd_unknown = 0; ev_host_idle = 0;
    endtask

    // Inputs already driven; advance one clock and update the model
    task automatic step();
        logic [5:0] nf;
        nf = exp_flags(m_flags, bus_wr, bus_addr, bus_wdata, ev_timer_zero, ev_tx_done,
                       ev_rx_end, ev_cmd_finish, ev_cmd_unknown, ev_host_idle,
                       lvl_fifo_hi, lvl_fifo_lo, m_prev_hi, m_prev_lo);
        @(posedge clk);
        m_flags   = nf;
        if (bus_wr && bus_addr == 8'h06) m_en = bus_wdata[5:0];
        m_prev_hi = lvl_fifo_hi;
        m_prev_lo = lvl_fifo_lo;
        @(negedge clk);
        idle_inputs();
    endtask

    // Read-only check of one address plus the interrupt line
    task automatic peek(input string tag, input logic [7:0] a);
        bus_wr   = 0;
        bus_addr = a;
        #1;
        check8(tag, bus_rdata, exp_read(a));
        check8({tag, " irq"}, {7'd0, irq}, {7'd0, |(m_flags & m_en)});
    endtask

    task automatic host_write(input logic [7:0] a, input logic [7:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h1C0DE));
        idle_inputs();
        bus_addr = 8'h07;
        lvl_fifo_hi = 0; lvl_fifo_lo = 0;
        m_flags = 0; m_en = 0; m_prev_hi = 0; m_prev_lo = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        peek("R1 flags", 8'h07);
        peek("R1 enable", 8'h06);

        // R9 enable write and readback, upper bits ignored
        host_write(8'h06, 8'hFF); step();
        peek("R9 enable readback", 8'h06);

        // R2 set marked flags, including write-only bit 7 reading 0
        host_write(8'h07, 8'hA5); step();
        peek("R2 masked set", 8'h07);
        peek("R10 irq on", 8'h07);

        // R3 clear only the marked flags
        host_write(8'h07, 8'h05); step();
        peek("R3 masked clear", 8'h07);
        host_write(8'h07, 8'h3F); step();
        peek("R3 clear all", 8'h07);

        // R4 hardware strobes
        ev_timer_zero = 1; step(); peek("R4 timer", 8'h07);
        ev_tx_done = 1;    step(); peek("R4 tx", 8'h07);
        ev_rx_end = 1;     step(); peek("R4 rx", 8'h07);
        host_write(8'h07, 8'h3F); step();

        // R5 idle from finish and from unknown command
        ev_cmd_finish = 1; step(); peek("R5 finish", 8'h07);
        host_write(8'h07, 8'h04); step();
        ev_cmd_unknown = 1; step(); peek("R5 unknown", 8'h07);
        host_write(8'h07, 8'h04); step();

        // R6 host-started idle suppresses the idle flag
        ev_cmd_finish = 1; ev_host_idle = 1; step(); peek("R6 suppressed", 8'h07);
        ev_cmd_unknown = 1; ev_host_idle = 1; step(); peek("R6 unknown suppressed", 8'h07);

        // R7 alert edges; held level does not re-set after a clear
        lvl_fifo_hi = 1; step(); peek("R7 hi rise", 8'h07);
        host_write(8'h07, 8'h02); step(); peek("R7 hi clear", 8'h07);
        step(); step(); peek("R7 hi held no retrigger", 8'h07);
        lvl_fifo_lo = 1; step(); peek("R7 lo rise", 8'h07);
        lvl_fifo_hi = 0; lvl_fifo_lo = 0; step();
        host_write(8'h07, 8'h3F); step();

        // R8 hardware set wins over same-cycle clear
        host_write(8'h07, 8'h20); ev_timer_zero = 1; step(); peek("R8 timer vs clear", 8'h07);
        host_write(8'h07, 8'h01); lvl_fifo_lo = 1; step(); peek("R8 alert vs clear", 8'h07);
        lvl_fifo_lo = 0;

        // R10 enable gating
        host_write(8'h06, 8'h00); step(); peek("R10 masked off", 8'h07);
        host_write(8'h06, 8'h20); step(); peek("R10 one enable", 8'h07);

        // R11 other addresses ignored and read zero
        host_write(8'h05, 8'h3F); step(); peek("R11 flags kept", 8'h07);
        host_write(8'h08, 8'hBF); step(); peek("R11 enable kept", 8'h06);
        peek("R11 other read", 8'h10);

        // Random mix covering R2 R3 R4 R5 R6 R7 R8 R10
        for (int i = 0; i < 4000; i++) begin
            logic [2:0] sel;
            ev_timer_zero  = ($urandom % 8) == 0;
            ev_tx_done     = ($urandom % 8) == 0;
            ev_rx_end      = ($urandom % 8) == 0;
            ev_cmd_finish  = ($urandom % 8) == 0;
            ev_cmd_unknown = ($urandom % 12) == 0;
            ev_host_idle   = ($urandom % 4) == 0;
            if (($urandom % 5) == 0) lvl_fifo_hi = ~lvl_fifo_hi;
            if (($urandom % 5) == 0) lvl_fifo_lo = ~lvl_fifo_lo;
            sel = 3'($urandom % 8);
            if (sel < 3) begin
                host_write(sel == 2 ? 8'h06 : 8'h07, 8'($urandom));
            end else if (sel == 3) begin
                host_write(8'($urandom), 8'($urandom));
            end
            step();
            peek("R4 random flags", 8'h07);
            peek("R10 random enable", 8'h06);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule